// File: doc/BRIEF.md
# Legacy memory region attribute router

This block sits beside a host memory controller and makes, for every host memory access, two decisions. It decides whether the access is served by DRAM or passed to the memory-mapped I/O path, and it decides which DRAM row the access falls in. The decision is combinational on the access inputs. It is shaped by a small set of byte-wide configuration registers, which are loaded through a simple write port.

The block has thirteen 2-bit attribute fields. One covers the top 64 KB segment below 1 MB (0xF0000–0xFFFFF). The other twelve each cover one 16 KB slice of 0xC0000–0xEFFFF. Each field can route reads and writes independently, so a region can be read-only or write-only toward DRAM. A hole field can carve either 512 KB–640 KB or 15 MB–16 MB out of DRAM. Eight row-boundary registers hold the cumulative end address of each row in 8 MB units, which lets rows of unequal size and empty rows share one lookup.

Top module: `lmr_router`

## Requirements
- R1: After reset, all attribute fields read as 00, all row boundaries are 0 and no hole is enabled. As a result, every valid access is reported out of range and is not routed to DRAM.
- R2: While `acc_valid_i` is low, `to_dram_o`, `row_o` and `out_of_range_o` are all 0.
- R3: For a valid in-range access, `row_o` is the lowest index n such that the address is below boundary[n] × 8 MB. A row whose boundary equals that of the row before it is never selected.
- R4: A valid access at or above boundary[7] × 8 MB sets `out_of_range_o`, clears `to_dram_o` and drives `row_o` to 0. `to_dram_o` and `out_of_range_o` are never both 1.
- R5: Attribute field encoding: bit 0 enables reads to DRAM and bit 1 enables writes to DRAM. So 00 sends everything to I/O, 01 sends reads to DRAM, 10 sends writes to DRAM and 11 sends everything to DRAM. A direction whose bit is clear goes to I/O.
- R6: The 0xF0000–0xFFFFF field sits in bits [5:4] of config index 0. Config index k, for k from 1 to 6, holds two fields. Bits [1:0] cover the 16 KB slice at 0xC0000 + (2k−2)·16 KB, and bits [5:4] cover the next 16 KB slice. All other bits of indices 0–6 are ignored, and so are bits [1:0] of index 0.
- R7: Bits [7:6] of config index 16 select the hole. 00 means no hole. 01 sends 0x80000–0x9FFFF to I/O. 10 sends 0xF00000–0xFFFFFF to I/O. 11 behaves as no hole.
- R8: A valid in-range access that is outside 0xC0000–0xFFFFF and outside the enabled hole goes to DRAM, whether it is a read or a write.
- R9: Config index 8+n loads boundary[n] from `cfg_data_i[7:0]`. A write is captured on the rising clock edge while `cfg_we_i` is high, and it governs accesses from the next cycle on. Writes to indices not listed here (7 and 17–31) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | 32 | Access byte address |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 5 | Configuration register index |
| cfg_data_i | input | 8 | Configuration write data |
| to_dram_o | output | 1 | Access is served by DRAM |
| row_o | output | 3 | Selected DRAM row |
| out_of_range_o | output | 1 | Access lies at or above the last row boundary |

## Verification
The bench runs runs of equal boundaries, so that empty rows sit between populated ones. A decoder that picks the highest matching row, or one that compares with <= instead of <, would report an empty row or the neighbouring row. Accesses land exactly on each boundary and one byte below it, at the first and last byte of each 16 KB slice, and at the edges of both holes. A swapped field nibble, an off-by-one slice index or a hole decoded one block too wide would each flip `to_dram_o` at those points. It also writes reserved bits, unmapped indices and the reserved hole code, then checks that the routing the bench already expects does not change.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  typedef enum logic [1:0] {
    ATTR_IO = 2'b00,
    ATTR_RD = 2'b01,
    ATTR_WR = 2'b10,
    ATTR_RW = 2'b11
  } attr_e;

  typedef enum logic [1:0] {
    HOLE_NONE = 2'b00,
    HOLE_LOW  = 2'b01,
    HOLE_HIGH = 2'b10,
    HOLE_RSVD = 2'b11
  } hole_e;

  localparam int NUM_ATTR  = 13;
  localparam int ATTR_REGS = 7;
  localparam int BLK_SHIFT = 14;  // 16 KB attribute slice granularity
endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
  import lmr_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int CFG_AW   = 5
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [CFG_AW-1:0]                  sel_i,
  input  logic [7:0]                         data_i,
  output logic [NUM_ATTR-1:0][1:0]           attr_o,
  output logic [NUM_ROWS-1:0][BND_W-1:0]     bnd_o,
  output hole_e                              hole_o
);
  localparam int BND_BASE = 8;
  localparam int HOLE_IDX = BND_BASE + NUM_ROWS;

  logic [NUM_ATTR-1:0][1:0]       attr_q;
  logic [NUM_ROWS-1:0][BND_W-1:0] bnd_q;
  hole_e                          hole_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q <= '0;
      bnd_q  <= '0;
      hole_q <= HOLE_NONE;
    end else if (we_i) begin
      if (sel_i == CFG_AW'(0)) attr_q[0] <= data_i[5:4];
      for (int k = 1; k < ATTR_REGS; k++) begin
        if (sel_i == CFG_AW'(k)) begin
          attr_q[2*k-1] <= data_i[1:0];
          attr_q[2*k]   <= data_i[5:4];
        end
      end
      for (int n = 0; n < NUM_ROWS; n++) begin
        if (sel_i == CFG_AW'(BND_BASE + n)) bnd_q[n] <= data_i[BND_W-1:0];
      end
      if (sel_i == CFG_AW'(HOLE_IDX)) hole_q <= hole_e'(data_i[7:6]);
    end
  end

  assign attr_o = attr_q;
  assign bnd_o  = bnd_q;
  assign hole_o = hole_q;

  // R9
  bnd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == CFG_AW'(BND_BASE)) |=> (bnd_o[0] == $past(data_i[BND_W-1:0])));

  // R9
  hole_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == CFG_AW'(HOLE_IDX)) |=> (hole_o == hole_e'($past(data_i[7:6]))));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(attr_o) && $stable(bnd_o) && $stable(hole_o)));
endmodule

// File: rtl/lmr_row_decode.sv
module lmr_row_decode #(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int HI_W     = 9,
  localparam int ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [HI_W-1:0]                addr_hi_i,
  input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd_i,
  output logic [ROW_W-1:0]               row_o,
  output logic                           in_range_o
);
  logic [NUM_ROWS-1:0] below;

  for (genvar n = 0; n < NUM_ROWS; n++) begin : g_cmp
    assign below[n] = addr_hi_i < HI_W'(bnd_i[n]);
  end

  // lowest matching row wins, so empty rows are skipped
  always_comb begin
    row_o = '0;
    for (int n = NUM_ROWS - 1; n >= 0; n--) begin
      if (below[n]) row_o = ROW_W'(n);
    end
  end

  assign in_range_o = below[NUM_ROWS-1];

  // R3
  row_below_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_range_o |-> (addr_hi_i < HI_W'(bnd_i[row_o])));

  // R3
  row_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_range_o && row_o != '0) |-> (addr_hi_i >= HI_W'(bnd_i[row_o - ROW_W'(1)])));

  // R4
  range_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range_o |-> (addr_hi_i >= HI_W'(bnd_i[NUM_ROWS-1])));
endmodule

// File: rtl/lmr_attr_route.sv
module lmr_attr_route
  import lmr_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int BLK_W = ADDR_W - BLK_SHIFT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [BLK_W-1:0]         blk_i,    // address in 16 KB units
  input  logic                     write_i,
  input  logic [NUM_ATTR-1:0][1:0] attr_i,
  input  hole_e                    hole_i,
  output logic                     dram_ok_o
);
  logic       legacy, f_seg, hole_hit;
  logic [3:0] fld_idx;
  logic [1:0] fld;

  // 0xC0000..0xFFFFF: bits [19:18] of the byte address both set
  assign legacy  = (blk_i[BLK_W-1:6] == '0) && (blk_i[5:4] == 2'b11);
  assign f_seg   = legacy && (blk_i[3:2] == 2'b11);
  assign fld_idx = f_seg ? 4'd0 : blk_i[3:0] + 4'd1;
  assign fld     = attr_i[fld_idx];

  // low hole: 128 KB block 4; high hole: 1 MB block 15
  always_comb begin
    unique case (hole_i)
      HOLE_LOW:  hole_hit = (blk_i[BLK_W-1:3] == (BLK_W-3)'(4));
      HOLE_HIGH: hole_hit = (blk_i[BLK_W-1:6] == (BLK_W-6)'(15));
      default:   hole_hit = 1'b0;
    endcase
  end

  assign dram_ok_o = legacy ? (write_i ? fld[1] : fld[0]) : !hole_hit;

  // R5
  fseg_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_i[BLK_W-1:2] == (BLK_W-2)'(15) && attr_i[0] == ATTR_IO) |-> !dram_ok_o);

  // R5
  fseg_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_i[BLK_W-1:2] == (BLK_W-2)'(15) && attr_i[0] == ATTR_RW) |-> dram_ok_o);

  // R7
  hole_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hole_i == HOLE_HIGH && blk_i[BLK_W-1:6] == (BLK_W-6)'(15)) |-> !dram_ok_o);
endmodule

// File: rtl/lmr_router.sv
module lmr_router
  import lmr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_ROWS   = 8,
  parameter int BND_W      = 8,
  parameter int UNIT_SHIFT = 23,  // 8 MB boundary unit
  parameter int CFG_AW     = 5,
  localparam int ROW_W     = $clog2(NUM_ROWS),
  localparam int HI_W      = ADDR_W - UNIT_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_sel_i,
  input  logic [7:0]        cfg_data_i,
  output logic              to_dram_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              out_of_range_o
);
  logic [NUM_ATTR-1:0][1:0]       attr;
  logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
  hole_e                          hole;
  logic [ROW_W-1:0]               row;
  logic                           in_range, dram_ok;

  lmr_cfg_regs #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .sel_i (cfg_sel_i),
    .data_i(cfg_data_i),
    .attr_o(attr),
    .bnd_o (bnd),
    .hole_o(hole)
  );

  lmr_row_decode #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .HI_W(HI_W)
  ) u_rows (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_hi_i (acc_addr_i[ADDR_W-1:UNIT_SHIFT]),
    .bnd_i     (bnd),
    .row_o     (row),
    .in_range_o(in_range)
  );

  lmr_attr_route #(.ADDR_W(ADDR_W)) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blk_i    (acc_addr_i[ADDR_W-1:BLK_SHIFT]),
    .write_i  (acc_write_i),
    .attr_i   (attr),
    .hole_i   (hole),
    .dram_ok_o(dram_ok)
  );

  assign to_dram_o      = acc_valid_i && in_range && dram_ok;
  assign out_of_range_o = acc_valid_i && !in_range;
  assign row_o          = (acc_valid_i && in_range) ? row : '0;

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!to_dram_o && !out_of_range_o && row_o == '0));

  // R4
  route_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(to_dram_o && out_of_range_o));

  // R8
  plain_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !out_of_range_o && acc_addr_i >= ADDR_W'(32'h0010_0000)
     && acc_addr_i < ADDR_W'(32'h00F0_0000)) |-> to_dram_o);
endmodule

// File: tb/lmr_router_test.sv
module lmr_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic        to_dram, oor;
  logic [2:0]  row;

  int n_tests = 0;
  int n_fail  = 0;

  // shadow configuration, decoded from the requirements
  logic [1:0] m_attr [13];
  int         m_bnd  [8];
  int         m_hole;

  always #2.5 clk = ~clk;

  lmr_router uut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_write_i(acc_write),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .to_dram_o(to_dram), .row_o(row), .out_of_range_o(oor)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  // R6 R7 R9: bench-side decode of a config write
  task automatic cfg_write(int idx, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 5'(idx); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 0) m_attr[0] = 2'((data >> 4) & 3);
    else if (idx >= 1 && idx <= 6) begin
      m_attr[2*idx-1] = 2'(data & 3);
      m_attr[2*idx]   = 2'((data >> 4) & 3);
    end else if (idx >= 8 && idx <= 15) m_bnd[idx-8] = data & 8'hFF;
    else if (idx == 16) m_hole = (data >> 6) & 3;
  endtask

  // expected {to_dram, row, oor} for a valid access
  function automatic logic [4:0] model(logic [31:0] a, logic w);
    int hi = int'(a >> 23);
    int r = 0;
    logic [1:0] f;
    logic dr;
    if (hi >= m_bnd[7]) return {1'b0, 3'd0, 1'b1};           // R4
    for (int n = 7; n >= 0; n--) if (hi < m_bnd[n]) r = n;   // R3
    if (a >= 32'hC0000 && a <= 32'hFFFFF) begin              // R5 R6
      f  = (a >= 32'hF0000) ? m_attr[0] : m_attr[1 + ((a - 32'hC0000) >> 14)];
      dr = w ? f[1] : f[0];
    end else if (m_hole == 1 && a >= 32'h80000 && a <= 32'h9FFFF) dr = 1'b0;   // R7
    else if (m_hole == 2 && a >= 32'hF00000 && a <= 32'hFFFFFF) dr = 1'b0;
    else dr = 1'b1;                                          // R8
    return {dr, 3'(r), 1'b0};
  endfunction

  task automatic chk(logic [31:0] a, logic w, logic v, string req);
    logic [4:0] exp, got;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_write = w;
    #1;
    exp = v ? model(a, w) : 5'b0;
    got = {to_dram, row, oor};
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h wr=%0b valid=%0b got dram/row/oor=%0b/%0d/%0b exp=%0b/%0d/%0b",
               req, a, w, v, got[4], got[3:1], got[0], exp[4], exp[3:1], exp[0]);
    end
  endtask

  function automatic logic [31:0] pick_addr();
    int k = $urandom % 5;
    int b = m_bnd[$urandom % 8];
    case (k)
      0: return 32'hC0000 + ($urandom % 32'h40000);
      1: return 32'h70000 + ($urandom % 32'h40000);
      2: return 32'hEF0000 + ($urandom % 32'h120000);
      3: return (32'(b) << 23) - 32'($urandom % 2);
      default: return $urandom % ((32'(m_bnd[7]) + 2) << 23);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    foreach (m_attr[i]) m_attr[i] = 2'b00;
    foreach (m_bnd[i]) m_bnd[i] = 0;
    m_hole = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: reset state
    chk(32'h0, 1'b0, 1'b0, "R2");
    chk(32'h0, 1'b0, 1'b1, "R1");
    chk(32'hF0000, 1'b1, 1'b1, "R1");

    // R3 R4 R9: boundaries with empty rows 1, 4, 5
    cfg_write(8, 2);  cfg_write(9, 2);  cfg_write(10, 4); cfg_write(11, 5);
    cfg_write(12, 5); cfg_write(13, 5); cfg_write(14, 8); cfg_write(15, 10);
    chk(32'h0000_0000, 1'b0, 1'b1, "R3");
    chk(32'h00FF_FFFF, 1'b1, 1'b1, "R3");
    chk(32'h0100_0000, 1'b0, 1'b1, "R3");
    chk(32'h0200_0000, 1'b0, 1'b1, "R3");
    chk(32'h0280_0000, 1'b1, 1'b1, "R3");
    chk(32'h04FF_FFFF, 1'b0, 1'b1, "R3");
    chk(32'h0500_0000, 1'b0, 1'b1, "R4");
    chk(32'hFFFF_FFFF, 1'b1, 1'b1, "R4");

    // R5 R6: attribute fields, reserved bits, slice edges
    cfg_write(0, 8'h1F);
    chk(32'hF0000, 1'b0, 1'b1, "R5");
    chk(32'hFFFFF, 1'b1, 1'b1, "R5");
    cfg_write(1, 8'hCE);
    chk(32'hC0000, 1'b1, 1'b1, "R6");
    chk(32'hC3FFF, 1'b0, 1'b1, "R6");
    chk(32'hC4000, 1'b0, 1'b1, "R6");
    cfg_write(6, 8'h30);
    chk(32'hEC000, 1'b0, 1'b1, "R6");
    chk(32'hEFFFF, 1'b1, 1'b1, "R6");
    chk(32'hEBFFF, 1'b0, 1'b1, "R6");
    chk(32'hBFFFF, 1'b1, 1'b1, "R8");
    chk(32'h100000, 1'b0, 1'b1, "R8");

    // R7: hole codes
    cfg_write(16, 8'h40);
    chk(32'h80000, 1'b0, 1'b1, "R7");
    chk(32'h9FFFF, 1'b1, 1'b1, "R7");
    chk(32'hA0000, 1'b0, 1'b1, "R7");
    chk(32'h7FFFF, 1'b1, 1'b1, "R7");
    cfg_write(16, 8'h80);
    chk(32'hF00000, 1'b0, 1'b1, "R7");
    chk(32'hFFFFFF, 1'b1, 1'b1, "R7");
    chk(32'h1000000, 1'b0, 1'b1, "R7");
    chk(32'h80000, 1'b0, 1'b1, "R7");
    cfg_write(16, 8'hC0);
    chk(32'hF00000, 1'b0, 1'b1, "R7");
    chk(32'h80000, 1'b1, 1'b1, "R7");

    // R9: unmapped indices leave routing untouched
    cfg_write(7, 8'hFF);
    cfg_write(20, 8'hFF);
    chk(32'hC4000, 1'b0, 1'b1, "R9");
    chk(32'hE8000, 1'b1, 1'b1, "R9");
    chk(32'h0500_0000, 1'b0, 1'b1, "R9");

    // R2: idle with an in-range address
    chk(32'h0100_0000, 1'b0, 1'b0, "R2");

    // random configurations and accesses
    for (int rnd = 0; rnd < 4; rnd++) begin
      int b = $urandom % 3;
      for (int n = 0; n < 8; n++) begin
        cfg_write(8 + n, b);
        b = b + ($urandom % 3);
      end
      for (int k = 0; k < 7; k++) cfg_write(k, $urandom % 256);
      cfg_write(16, $urandom % 256);
      for (int t = 0; t < 400; t++)
        chk(pick_addr(), 1'($urandom % 2), 1'($urandom % 8 != 0), "R3/R5/R7/R8 random");
    end

    @(negedge clk);
    acc_valid = 1'b0;
    summary();
    $finish;
  end
endmodule